// File: doc/BRIEF.md
# SPI Register Access Bridge

This block lets an external SPI master read and write a bank of byte-wide configuration registers held in the core. The master lowers slave select and sends a command byte, then a start address byte, then any number of data bytes, each most significant bit first. Command 0x03 reads and command 0x02 writes. Each data byte in a write becomes one write strobe on the parallel register port. In a read, the register contents are shifted out on MISO.

Slave select may stay low after a data byte. The transfer then becomes a burst: the internal address counter steps by one per byte and wraps from the last register back to zero, so one command can sweep the whole register space from any start address. The SPI pins are oversampled by the system clock through two-flop synchronizers. The register port therefore lives entirely in the core clock domain. The core is expected to return `reg_rdata` combinationally from `reg_addr`. Each half period of the SPI clock must last at least four core clock cycles.

Top module: `spi_reg_bridge`

## Requirements
- R1: With command byte 0x03 and start address A, the first data byte shifted out on MISO, MSB first, equals register A.
- R2: With command byte 0x02, each completed data byte produces exactly one single-cycle `reg_we` pulse, with `reg_addr` set to the target register and `reg_wdata` set to the received byte.
- R3: In a read burst, each further data byte comes from the register one above the previous one.
- R4: In a write burst, each further data byte is written to the register one above the previous one.
- R5: After register NREG-1 (197 by default), the address counter returns to 0, in reads and in writes alike. `reg_addr` never reaches NREG or above.
- R6: A start address byte of NREG or higher is treated as address 0.
- R7: After any command byte other than 0x02 or 0x03, no `reg_we` pulse occurs and MISO stays 0 until slave select rises.
- R8: Raising slave select in the middle of a byte discards the partial byte without writing it. The next transaction starts again from a command byte.
- R9: While slave select is high, `spi_miso` is 0. With IDLE_HIZ=1 (the default), `spi_miso_oe` is also 0. While select is low, `spi_miso_oe` is 1.
- R10: MOSI is sampled on rising SPI clock edges. MISO changes only after falling edges, so it holds steady across each rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also used to oversample the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Slave select, active low |
| spi_sclk | input | 1 | SPI clock from the master, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| reg_addr | output | AW | Register address toward the core |
| reg_wdata | output | 8 | Write data toward the core |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data from the core for `reg_addr` |

## Verification
Single-byte reads and writes at fixed addresses establish the basic frame decode and the strobe timing. Bursts that start just below the top register tell correct wrapping apart from off-by-one wrapping or overflow past the top. Out-of-range start addresses, unknown command bytes and select raised mid-byte separate clamping, command rejection and partial-byte discard from ordinary transfers. Random reads and writes of random lengths, plus one full sweep of more than the whole space, cross-check the register contents against a model kept in the bench.

// File: rtl/spi_rb_pkg.sv
// Package: shared constants and the protocol phase type for the SPI
// register bridge. Assumes byte-wide commands.
package spi_rb_pkg;
    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_WRITE = 8'h02;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_DEAD = 2'd3
    } phase_e;
endpackage

// File: rtl/spi_rb_sync.sv
// Module: multi-bit two-or-more-stage synchronizer for asynchronous pins.
// Assumes each bit is independent; RST_VAL gives each bit's reset level.
module spi_rb_sync #(
    parameter int             N       = 3,
    parameter int             STAGES  = 2,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES-1:0] pipe_q;
        // Shift the pin through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe_q <= {STAGES{RST_VAL[g]}};
            else        pipe_q <= {pipe_q[STAGES-2:0], din[g]};
        end
        assign dout[g] = pipe_q[STAGES-1];
    end
endmodule

// File: rtl/spi_rb_shift.sv
// Module: serial-to-byte receiver. Shifts one bit per sample pulse, MSB
// first, and reports a completed byte one cycle later. Assumes sample
// pulses are at least two cycles apart. clr drops any partial byte.
module spi_rb_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         sample,
    input  logic         din,
    output logic         byte_done,
    output logic [W-1:0] byte_out
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sr_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic [W-1:0]  byte_q;

    // Collect bits and flag each full byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sr_q   <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
            byte_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (sample) begin
                sr_q <= {sr_q[W-2:0], din};
                if (cnt_q == CW'(W-1)) begin
                    cnt_q  <= '0;
                    byte_q <= {sr_q[W-2:0], din};
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign byte_done = done_q;
    assign byte_out  = byte_q;

    // R8
    clr_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && !done_q));
endmodule

// File: rtl/spi_rb_ctrl.sv
// Module: protocol engine. Decodes command and address bytes, drives the
// register port, keeps the wrapping address counter and shifts read data
// out on falling-edge pulses. Assumes reg_rdata follows reg_addr in the
// same cycle and that edges of the SPI clock are at least four cycles apart.
module spi_rb_ctrl
    import spi_rb_pkg::*;
#(
    parameter int NREG = 198,
    parameter int AW   = 8,
    parameter int DW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          byte_done,
    input  logic [DW-1:0] byte_in,
    input  logic          shift_out,
    input  logic [DW-1:0] reg_rdata,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          miso
);
    localparam logic [AW-1:0] LAST = AW'(NREG - 1);

    phase_e        ph_q;
    logic          rd_q;
    logic [AW-1:0] addr_q;
    logic          we_q;
    logic [DW-1:0] wdata_q;
    logic          ld_q;
    logic [DW-1:0] tx_q;
    logic          miso_q;

    function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
        return (a == LAST) ? '0 : a + 1'b1;
    endfunction

    // Advance the protocol phase, address counter, write strobe and read shifter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ph_q    <= PH_CMD;
            rd_q    <= 1'b0;
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            ld_q    <= 1'b0;
            tx_q    <= '0;
            miso_q  <= 1'b0;
        end else begin
            we_q <= 1'b0;
            ld_q <= 1'b0;
            if (we_q) addr_q <= next_addr(addr_q);
            if (ld_q) begin
                tx_q <= reg_rdata;
            end else if (shift_out && ph_q == PH_DATA && rd_q) begin
                miso_q <= tx_q[DW-1];
                tx_q   <= {tx_q[DW-2:0], 1'b0};
            end
            if (byte_done) begin
                case (ph_q)
                    PH_CMD: begin
                        if (byte_in == CMD_READ) begin
                            ph_q <= PH_ADDR;
                            rd_q <= 1'b1;
                        end else if (byte_in == CMD_WRITE) begin
                            ph_q <= PH_ADDR;
                            rd_q <= 1'b0;
                        end else begin
                            ph_q <= PH_DEAD;
                        end
                    end
                    PH_ADDR: begin
                        addr_q <= (int'(byte_in) < NREG) ? AW'(byte_in) : '0;
                        ph_q   <= PH_DATA;
                        ld_q   <= rd_q;
                    end
                    PH_DATA: begin
                        if (rd_q) begin
                            addr_q <= next_addr(addr_q);
                            ld_q   <= 1'b1;
                        end else begin
                            we_q    <= 1'b1;
                            wdata_q <= byte_in;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign reg_addr  = addr_q;
    assign reg_wdata = wdata_q;
    assign reg_we    = we_q;
    assign miso      = miso_q;

    // R2
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |=> !we_q);
    // R5
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(addr_q) < NREG);
    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_q && addr_q == LAST && !clr) |=> addr_q == '0);
    // R7
    dead_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_DEAD) |-> (!we_q && !miso_q));
    // R10
    miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_out && !clr) |=> $stable(miso_q));
endmodule

// File: rtl/spi_reg_bridge.sv
// Module: top of the SPI register bridge. Synchronizes the SPI pins to clk,
// finds SPI clock edges, and joins the byte receiver to the protocol engine.
// Assumes an idle-low SPI clock (data in on rising, data out on falling).
module spi_reg_bridge #(
    parameter int NREG     = 198,
    parameter int AW       = $clog2(NREG),
    parameter bit IDLE_HIZ = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_cs_n,
    input  logic          spi_sclk,
    input  logic          spi_mosi,
    output logic          spi_miso,
    output logic          spi_miso_oe,
    output logic [AW-1:0] reg_addr,
    output logic [7:0]    reg_wdata,
    output logic          reg_we,
    input  logic [7:0]    reg_rdata
);
    localparam int DW = 8;

    logic [2:0] pins_s;
    logic       cs_hi, sclk_s, mosi_s;
    logic       sclk_d;
    logic       sclk_rise, sclk_fall;
    logic       byte_done;
    logic [DW-1:0] byte_rx;
    logic       miso_int;

    spi_rb_sync #(.N(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_cs_n, spi_sclk, spi_mosi}),
        .dout (pins_s)
    );
    assign cs_hi  = pins_s[2];
    assign sclk_s = pins_s[1];
    assign mosi_s = pins_s[0];

    // Remember the previous synchronized SPI clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end
    assign sclk_rise = !cs_hi && sclk_s && !sclk_d;
    assign sclk_fall = !cs_hi && !sclk_s && sclk_d;

    spi_rb_shift #(.W(DW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cs_hi),
        .sample   (sclk_rise),
        .din      (mosi_s),
        .byte_done(byte_done),
        .byte_out (byte_rx)
    );

    spi_rb_ctrl #(.NREG(NREG), .AW(AW), .DW(DW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cs_hi),
        .byte_done(byte_done),
        .byte_in  (byte_rx),
        .shift_out(sclk_fall),
        .reg_rdata(reg_rdata),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_we   (reg_we),
        .miso     (miso_int)
    );

    assign spi_miso = miso_int;
    if (IDLE_HIZ) begin : g_hiz
        assign spi_miso_oe = !cs_hi;
    end else begin : g_drive
        assign spi_miso_oe = 1'b1;
    end

    // R9
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !spi_miso);
endmodule

// File: tb/sim_spi_reg_bridge.sv
module sim_spi_reg_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 80;
    localparam int NREG       = 198;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic       miso, miso_oe, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;

    logic [7:0] mem   [NREG];
    logic [7:0] exp_m [NREG];
    logic [7:0] log_a [1024];
    logic [7:0] log_d [1024];
    int         log_n = 0;
    logic [7:0] tx_buf [256];
    logic [7:0] rx_buf [256];
    int         n_run = 0, n_fail = 0, rise_glitch = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_reg_bridge u0 (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
        .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    function automatic int nxt(input int a);
        return (a == NREG - 1) ? 0 : a + 1;
    endfunction

    always_comb reg_rdata = (int'(reg_addr) < NREG) ? mem[reg_addr] : 8'h00;

    // fake core register file plus write log
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= init_val(i);
        end else if (reg_we) begin
            if (int'(reg_addr) < NREG) mem[reg_addr] <= reg_wdata;
            log_a[log_n % 1024] <= reg_addr;
            log_d[log_n % 1024] <= reg_wdata;
            log_n <= log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic spi_bit(input logic b, output logic r);
        logic r2;
        mosi = b;
        #(HALF);
        r = miso;
        sclk = 1'b1;
        #(HALF/2);
        r2 = miso;
        if (r2 !== r) rise_glitch++;
        #(HALF/2);
        sclk = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] o, output logic [7:0] r);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            spi_bit(o[i], b);
            r[i] = b;
        end
    endtask

    // cmd, start address, n data bytes, then cut extra bits before select rises
    task automatic txn(input logic [7:0] cmd, input logic [7:0] a, input int n, input int cut);
        logic [7:0] junk;
        logic b;
        @(negedge clk);
        cs_n = 1'b0;
        #(HALF);
        spi_byte(cmd, junk);
        spi_byte(a, junk);
        check(miso_oe === 1'b1, "R9 oe active", int'(miso_oe), 1);
        for (int i = 0; i < n; i++) spi_byte(tx_buf[i], rx_buf[i]);
        for (int i = 0; i < cut; i++) spi_bit(1'b1, b);
        #(HALF);
        cs_n = 1'b1;
        #(HALF*4);
    endtask

    task automatic do_write(input int a, input int n, input string req);
        int base, ad, got;
        base = log_n;
        for (int i = 0; i < n; i++) tx_buf[i] = 8'($urandom);
        txn(8'h02, 8'(a), n, 0);
        got = log_n - base;
        check(got == n, {req, " strobe count"}, got, n);
        ad = (a < NREG) ? a : 0;
        for (int i = 0; i < n && i < got; i++) begin
            check(int'(log_a[(base+i)%1024]) == ad, {req, " write addr"},
                  int'(log_a[(base+i)%1024]), ad);
            check(log_d[(base+i)%1024] == tx_buf[i], {req, " write data"},
                  int'(log_d[(base+i)%1024]), int'(tx_buf[i]));
            exp_m[ad] = tx_buf[i];
            ad = nxt(ad);
        end
    endtask

    task automatic do_read(input int a, input int n, input string req);
        int ad, g0;
        g0 = rise_glitch;
        txn(8'h03, 8'(a), n, 0);
        ad = (a < NREG) ? a : 0;
        for (int i = 0; i < n; i++) begin
            check(rx_buf[i] == exp_m[ad], req, int'(rx_buf[i]), int'(exp_m[ad]));
            ad = nxt(ad);
        end
        check(rise_glitch == g0, "R10 miso steady at rise", rise_glitch - g0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int base, a, n;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NREG; i++) exp_m[i] = init_val(i);
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R9 reset/idle state
        check(miso === 1'b0, "R9 idle miso", int'(miso), 0);
        check(miso_oe === 1'b0, "R9 idle oe", int'(miso_oe), 0);
        check(reg_we === 1'b0, "R2 idle strobe", int'(reg_we), 0);

        do_write(5, 1, "R2");
        do_read(5, 1, "R1");
        do_read(40, 3, "R3");
        do_write(195, 5, "R4 R5");
        do_read(194, 6, "R3 R5");
        do_write(200, 2, "R6");
        do_read(250, 2, "R6 read");

        // R7 unknown commands
        foreach (tx_buf[i]) tx_buf[i] = 8'hFF;
        base = log_n;
        txn(8'hA5, 8'd7, 3, 0);
        for (int i = 0; i < 3; i++) check(rx_buf[i] == 8'h00, "R7 miso low", int'(rx_buf[i]), 0);
        txn(8'h00, 8'd9, 2, 0);
        for (int i = 0; i < 2; i++) check(rx_buf[i] == 8'h00, "R7 miso low", int'(rx_buf[i]), 0);
        check(log_n == base, "R7 no strobe", log_n - base, 0);
        do_read(7, 3, "R7 contents kept");

        // R8 select raised mid-byte
        base = log_n;
        tx_buf[0] = 8'h3C;
        txn(8'h02, 8'd10, 1, 5);
        check(log_n - base == 1, "R8 partial byte dropped", log_n - base, 1);
        exp_m[10] = 8'h3C;
        base = log_n;
        txn(8'h02, 8'd20, 0, 3);
        check(log_n == base, "R8 no strobe in address", log_n - base, 0);
        do_read(10, 2, "R8 fresh frame");
        check(miso === 1'b0 && miso_oe === 1'b0, "R9 idle after frame", int'(miso_oe), 0);

        // random mix
        for (int k = 0; k < 30; k++) begin
            a = ($urandom % 8 == 0) ? 190 + int'($urandom % 8) : int'($urandom % NREG);
            n = 1 + int'($urandom % 6);
            if ($urandom % 2) do_write(a, n, "R4 random");
            else              do_read(a, n, "R3 random");
        end

        // full sweep beyond the register space
        do_read(100, NREG + 1, "R5 sweep");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule